// File: doc/BRIEF.md
# Indexed Bit Test, Set and Clear Unit

This unit applies one of three single-bit operations to a byte: test a chosen bit, force it to one, or force it to zero. A 3-bit index picks the bit. A test leaves the byte as it is and builds a new flag byte. The flag layout, from bit 7 down to bit 0, is sign, zero, copy-5, half-carry, copy-3, parity/overflow, subtract, carry. A set or a clear changes the byte and passes the incoming flags through untouched.

The operand can come from a register or from memory. A flag called `mem_src_i` tells the unit which. For a memory operand, the two copy bits of a test are taken from the high byte of the effective address. The caller supplies that byte; the unit does no address arithmetic and no memory timing. A memory set or clear always asserts the memory write. If a secondary register destination is enabled, the same modified byte is also written to that register, even if the memory write has no effect.

Requests arrive with `valid_i`, and all outputs are registered one cycle later.

Top module: `bitop_unit`

## Requirements
- R1: While rst_ni is low, valid_o, mem_we_o and reg_we_o are 0 and result_o and flags_o are 0x00.
- R2: valid_o is high exactly in the cycle after one with valid_i high. mem_we_o and reg_we_o are never high while valid_o is low.
- R3: For a test (op_i=2'b00), flags_o bit 6 (zero) and bit 2 (parity/overflow) are both 1 when operand bit idx_i is 0, and both 0 otherwise.
- R4: For a test, flags_o bit 7 (sign) is 1 only when idx_i is 7 and operand bit 7 is 1.
- R5: For a test, flags_o bit 4 (half-carry) is 1, bit 1 (subtract) is 0, and bit 0 (carry) equals flags_i bit 0.
- R6: For a test, flags_o bits 5 and 3 equal operand bits 5 and 3 when mem_src_i is 0. They equal addr_hi_i bits 5 and 3 when mem_src_i is 1.
- R7: For a test, result_o equals the operand and neither write enable is asserted.
- R8: For a set (op_i=2'b01), result_o is the operand with bit idx_i forced to 1. For a clear (op_i=2'b10), it is the operand with that bit forced to 0. All other bits are unchanged.
- R9: For a set or a clear, flags_o equals flags_i.
- R10: For a set or a clear with mem_src_i=0, reg_we_o=1 and mem_we_o=0. With mem_src_i=1, mem_we_o=1 and reg_we_o equals copy_en_i, and both writes carry the same result_o.
- R11: op_i=2'b11 is a no-operation: result_o equals the operand, flags_o equals flags_i, and no write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 test, 01 set, 10 clear, 11 no-op |
| idx_i | input | 3 | Bit index |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte |
| addr_hi_i | input | 8 | High byte of effective address |
| mem_src_i | input | 1 | Operand comes from memory |
| copy_en_i | input | 1 | Also write memory result to a register |
| valid_o | output | 1 | Result strobe |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |
| mem_we_o | output | 1 | Memory write enable |
| reg_we_o | output | 1 | Register write enable |

## Verification
The hardest case is telling the operand apart from the address byte as the source of the copy bits. A pair of values that agree in bits 5 and 3 hides a swapped multiplexer. The stimulus therefore pairs operands with address bytes that are complementary in those bits, for example 0x28 against 0xD7, and runs every index under both settings of mem_src_i. For the sign bit, operands with bit 7 set are tested at every index, so a sign taken from the unmasked byte would show up at indices 0 to 6.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_NOP  = 2'b11
  } bitop_e;

  localparam int unsigned FLAG_W = 8;
  localparam int unsigned F_S    = 7;
  localparam int unsigned F_Z    = 6;
  localparam int unsigned F_Y    = 5;
  localparam int unsigned F_H    = 4;
  localparam int unsigned F_X    = 3;
  localparam int unsigned F_PV   = 2;
  localparam int unsigned F_N    = 1;
  localparam int unsigned F_C    = 0;
endpackage

// File: rtl/bitop_mask_gen.sv
module bitop_mask_gen #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign mask_o[g] = (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/bitop_flag_calc.sv
module bitop_flag_calc
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] addr_hi_i,
  input  logic              mem_src_i,
  output logic [FLAG_W-1:0] test_flags_o
);
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] copy_src;
  logic              zero;

  assign masked   = operand_i & mask_i;
  assign zero     = ~|masked;
  // memory operand: copy bits follow the address high byte
  assign copy_src = mem_src_i ? addr_hi_i : operand_i;

  always_comb begin
    test_flags_o       = '0;
    test_flags_o[F_S]  = masked[DATA_W-1];
    test_flags_o[F_Z]  = zero;
    test_flags_o[F_Y]  = copy_src[F_Y];
    test_flags_o[F_H]  = 1'b1;
    test_flags_o[F_X]  = copy_src[F_X];
    test_flags_o[F_PV] = zero;
    test_flags_o[F_N]  = 1'b0;
    test_flags_o[F_C]  = flags_i[F_C];
  end
endmodule

// File: rtl/bitop_result_sel.sv
module bitop_result_sel
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  bitop_e            op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] test_flags_i,
  input  logic              mem_src_i,
  input  logic              copy_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              mem_we_o,
  output logic              reg_we_o
);
  always_comb begin
    result_o = operand_i;
    flags_o  = flags_i;
    mem_we_o = 1'b0;
    reg_we_o = 1'b0;
    unique case (op_i)
      OP_TEST: flags_o = test_flags_i;
      OP_SET, OP_CLR: begin
        result_o = (op_i == OP_SET) ? (operand_i | mask_i) : (operand_i & ~mask_i);
        mem_we_o = mem_src_i;
        // register copy happens even if the memory write is lost
        reg_we_o = mem_src_i ? copy_en_i : 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] addr_hi_i,
  input  logic              mem_src_i,
  input  logic              copy_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              mem_we_o,
  output logic              reg_we_o
);
  logic [DATA_W-1:0] mask;
  logic [FLAG_W-1:0] test_flags;
  logic [DATA_W-1:0] res_d;
  logic [FLAG_W-1:0] flags_d;
  logic              mem_we_d, reg_we_d;
  bitop_e            op;

  assign op = bitop_e'(op_i);

  bitop_mask_gen #(.DATA_W(DATA_W)) mask_i (
    .idx_i (idx_i),
    .mask_o(mask)
  );

  bitop_flag_calc #(.DATA_W(DATA_W)) flag_i (
    .operand_i   (operand_i),
    .mask_i      (mask),
    .flags_i     (flags_i),
    .addr_hi_i   (addr_hi_i),
    .mem_src_i   (mem_src_i),
    .test_flags_o(test_flags)
  );

  bitop_result_sel #(.DATA_W(DATA_W)) sel_i (
    .op_i        (op),
    .operand_i   (operand_i),
    .mask_i      (mask),
    .flags_i     (flags_i),
    .test_flags_i(test_flags),
    .mem_src_i   (mem_src_i),
    .copy_en_i   (copy_en_i),
    .result_o    (res_d),
    .flags_o     (flags_d),
    .mem_we_o    (mem_we_d),
    .reg_we_o    (reg_we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
      mem_we_o <= 1'b0;
      reg_we_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      mem_we_o <= valid_i & mem_we_d;
      reg_we_o <= valid_i & reg_we_d;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flags_d;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              mem_src_i,
  input logic              copy_en_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              mem_we_o,
  input logic              reg_we_o
);
  logic is_test, is_mod;
  assign is_test = valid_i && (op_i == 2'b00);
  assign is_mod  = valid_i && (op_i == 2'b01 || op_i == 2'b10);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!valid_o && !mem_we_o && !reg_we_o);
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_no_idle_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!mem_we_o && !reg_we_o));
  assert_zero_pv_tie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_test |=> (flags_o[F_Z] == flags_o[F_PV]));
  assert_hnc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_test |=> (flags_o[F_H] && !flags_o[F_N] && flags_o[F_C] == $past(flags_i[F_C])));
  assert_test_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_test |=> (!mem_we_o && !reg_we_o && result_o == $past(operand_i)));
  assert_mod_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mod |=> (flags_o == $past(flags_i)));
  assert_reg_route_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mod && !mem_src_i) |=> (reg_we_o && !mem_we_o));
  assert_mem_route_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mod && mem_src_i) |=> (mem_we_o && reg_we_o == $past(copy_en_i)));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .operand_i(operand_i),
  .flags_i  (flags_i),
  .mem_src_i(mem_src_i),
  .copy_en_i(copy_en_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .flags_o  (flags_o),
  .mem_we_o (mem_we_o),
  .reg_we_o (reg_we_o)
);

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [2:0] idx_i = '0;
  logic [7:0] operand_i = '0, flags_i = '0, addr_hi_i = '0;
  logic       mem_src_i = 1'b0, copy_en_i = 1'b0;
  logic       valid_o, mem_we_o, reg_we_o;
  logic [7:0] result_o, flags_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    logic       mwe;
    logic       rwe;
    string      t_res;
    string      t_flg;
    string      t_we;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;

  bitop_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .idx_i(idx_i),
    .operand_i(operand_i), .flags_i(flags_i), .addr_hi_i(addr_hi_i),
    .mem_src_i(mem_src_i), .copy_en_i(copy_en_i), .valid_o(valid_o),
    .result_o(result_o), .flags_o(flags_o), .mem_we_o(mem_we_o), .reg_we_o(reg_we_o)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] opd,
                                 input logic [7:0] flg, input logic [7:0] ahi, input logic ms, input logic ce);
    exp_t e;
    logic [7:0] src;
    logic bitv;
    bitv = opd[idx];
    src  = ms ? ahi : opd;
    e.res = opd; e.flg = flg; e.mwe = 0; e.rwe = 0;
    e.t_res = "R11"; e.t_flg = "R11"; e.t_we = "R11";
    case (op)
      2'b00: begin
        // R3 R4 R5 R6: S Z Y H X PV N C
        e.flg = {(idx == 3'd7) && bitv, !bitv, src[5], 1'b1, src[3], !bitv, 1'b0, flg[0]};
        e.t_res = "R7"; e.t_flg = "R3/R4/R5/R6"; e.t_we = "R7";
      end
      2'b01, 2'b10: begin
        e.res = opd;
        e.res[idx] = (op == 2'b01);
        e.mwe = ms;
        e.rwe = ms ? ce : 1'b1;
        e.t_res = "R8"; e.t_flg = "R9"; e.t_we = "R10";
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] opd,
                       input logic [7:0] flg, input logic [7:0] ahi, input logic ms, input logic ce);
    @(negedge clk_i);
    valid_i = 1; op_i = op; idx_i = idx; operand_i = opd; flags_i = flg;
    addr_hi_i = ahi; mem_src_i = ms; copy_en_i = ce;
    sb_q.push_back(model(op, idx, opd, flg, ahi, ms, ce));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 0; operand_i = ~operand_i; flags_i = ~flags_i;
    end
  endtask

  // monitor: compare each produced result against the queue head
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni) begin
        if (valid_o) begin
          if (sb_q.size() == 0) begin
            check(0, "R2 unexpected valid_o", 8'(valid_o), 8'h00);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(result_o == e.res, e.t_res, result_o, e.res);
            check(flags_o == e.flg, e.t_flg, flags_o, e.flg);
            check({mem_we_o, reg_we_o} == {e.mwe, e.rwe}, e.t_we,
                  8'({mem_we_o, reg_we_o}), 8'({e.mwe, e.rwe}));
          end
        end else begin
          check(!mem_we_o && !reg_we_o, "R2 write while idle",
                8'({mem_we_o, reg_we_o}), 8'h00);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(!valid_o && !mem_we_o && !reg_we_o, "R1 strobes", 8'({valid_o, mem_we_o, reg_we_o}), 8'h00);
    check(result_o == 8'h00, "R1 result", result_o, 8'h00);
    check(flags_o == 8'h00, "R1 flags", flags_o, 8'h00);
    rst_ni = 1'b1;
    idle(2);
    // test over every index, both sources, complementary copy bits (R3 R4 R5 R6 R7)
    foreach (pats[p]) begin
      for (int ms = 0; ms < 2; ms++) begin
        for (int b = 0; b < 8; b++) begin
          drive(2'b00, 3'(b), pats[p], (b % 2) ? 8'h01 : 8'hFE, ms ? 8'hD7 : 8'h28, 1'(ms), 1'b0);
        end
      end
    end
    for (int b = 0; b < 8; b++) drive(2'b00, 3'(b), 8'h80, 8'h00, 8'h28, 1'b0, 1'b0); // R4
    idle(3);
    // set / clear, all routes (R8 R9 R10)
    foreach (pats[p]) begin
      for (int b = 0; b < 8; b++) begin
        for (int rt = 0; rt < 3; rt++) begin
          drive(2'b01, 3'(b), pats[p], 8'h3C ^ 8'(b), 8'hAA, rt != 0, rt == 2);
          drive(2'b10, 3'(b), pats[p], 8'hC3 ^ 8'(b), 8'h55, rt != 0, rt == 1);
        end
        idle(1);
      end
    end
    // no-op (R11)
    for (int b = 0; b < 8; b++) drive(2'b11, 3'(b), pats[b % 4] ^ 8'(b), 8'h96, 8'h69, 1'(b % 2), 1'b1);
    idle(2);
    // mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'b000) idle(1);
      else drive(r[1:0], r[4:2], r[12:5], r[20:13], r[28:21], r[29], r[30]);
    end
    idle(4);
    check(sb_q.size() == 0, "R2 all results delivered", 8'(sb_q.size()), 8'h00);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule